// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block is the host-side front end for PCI configuration cycles. The CPU reaches it through two 4 KiB address windows. The index window holds one 32-bit configuration index register. Any access to the data window starts a configuration read or write on a downstream request port. Before the request goes out, the block turns the stored index and the low bits of the data-window offset into a standard type-1 style configuration address.

Three index encodings are accepted. Bit 31 of the index picks a pass-through form. Failing that, bit 0 picks an index that is already in type-1 form. With neither bit set, the index is a type-0 form in which a one-hot device select in bits 31:11 becomes a slot number through a search for the lowest set bit. The access size and the offset become byte enables and lane-aligned data. All data is little-endian.

The same block also rotates the four interrupt pins of each attached device onto four shared level interrupt outputs. Output k feeds interrupt controller line 0x1B + k, so the outputs reach lines 0x1B to 0x1E.

Top module: `pcicfg_bridge`

## Requirements
- R1: The index register resets to zero. A read in the index window (cpu_req_addr bit 12 = 0) returns all 32 bits of the index unchanged, whatever the offset and size. cpu_rsp_valid rises the cycle after the request is accepted. An index write changes only the bytes that its byte enables select.
- R2: cpu_req_addr bit 12 selects the window: 0 is the index window and 1 is the data window. Bits 11:0 are the offset inside the window. Only data-window accesses produce a downstream request.
- R3: When index bit 31 is set, the downstream address is the index ORed with offset bits 1:0.
- R4: When index bit 31 is clear and bit 0 is set, the downstream address is the index with bits 2:0 cleared, ORed with offset bits 2:0.
- R5: When index bits 31 and 0 are both clear, the address is built from four parts: index bits 7:3 in place, offset bits 2:0, the slot shifted left by 11, and index bits 10:8 (the function) shifted left by 8. The slot is the bit position, counted from bit 0, of the lowest set bit in index bits 31:11. Index bits 2:0 are ignored.
- R6: In the type-0 form, if no bit in index bits 31:11 is set, the slot is all ones and address bits 31:11 are all set.
- R7: The size code in cpu_req_size sets the access width and the lane:
  - Code 0 is one byte: be = 1 << off[1:0].
  - Code 1 is two bytes: be = 4'b0011 when off[1] = 0, and 4'b1100 when off[1] = 1.
  - Codes 2 and 3 are four bytes: be = 4'hF.

  Write data enters right-aligned and is shifted up to the lowest enabled lane. The same byte enables and lane shift apply to index-window writes.
- R8: dn_req_valid, together with the address, byte enables and data, stays stable until dn_req_ready is seen. A data-window write completes when the downstream side accepts it, and it produces no cpu_rsp_valid.
- R9: A data-window read holds cpu_req_ready low until dn_rsp_valid arrives. cpu_rsp_valid rises the cycle after dn_rsp_valid. cpu_rsp_rdata carries the response shifted down from the lowest enabled lane, with the bytes beyond the access size set to zero.
- R10: Pin p of device d (INTA = 0 to INTD = 3) drives interrupt output (irq_devfn[d][15:11] + p) mod 4. Each output is the OR of all levels routed to it and is registered, so it follows its inputs one clock later.
- R11: During and straight after reset, intx_out, dn_req_valid and cpu_rsp_valid are 0 and cpu_req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | CPU access request |
| cpu_req_ready | output | 1 | Block can accept a CPU access |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | WIN_AW+1 | Window select (top bit) and window offset |
| cpu_req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| cpu_req_wdata | input | 32 | Right-aligned write data |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_rdata | output | 32 | Right-aligned read data |
| dn_req_valid | output | 1 | Downstream configuration request |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_req_write | output | 1 | Downstream request is a write |
| dn_req_addr | output | 32 | Translated configuration address |
| dn_req_be | output | 4 | Byte enables |
| dn_req_wdata | output | 32 | Lane-aligned write data |
| dn_rsp_valid | input | 1 | Downstream read response valid |
| dn_rsp_rdata | input | 32 | Lane-aligned read response |
| irq_devfn | input | NUM_DEV x DEVFN_W | Device/function value for each interrupt source |
| irq_level | input | NUM_DEV x 4 | Level of each device's four interrupt pins |
| intx_out | output | 4 | Shared interrupt outputs (to lines 0x1B to 0x1E) |

## Verification
The bench drives the type-0 slot search with several device-select bits set at once and with bit 30 set alone. A search that picks the highest bit, or is off by one position, shows up as a wrong slot field. An empty device-select field must fill address bits 31:11 with ones; a design that outputs slot 0 there would produce address 0x300 instead of 0xFFFFFB00. The type-1 and pass-through cases use index values with stray low bits set, which catches clearing or ORing the wrong number of offset bits. Byte, halfword and word accesses at shifted offsets expose enable or lane-shift mistakes in both directions. Interrupt patterns with device numbers 11 and 15 check the wraparound in the modulo-4 rotation.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int CFG_DW   = 32;
  localparam int CFG_BE_W = CFG_DW / 8;
  localparam int INTX_N   = 4;
  localparam int PIN_N    = 4;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_HALF     = 2'd1,
    SZ_WORD     = 2'd2,
    SZ_WORD_ALT = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } fsm_e;
endpackage

// File: rtl/pcicfg_addr_xlat.sv
module pcicfg_addr_xlat
  import pcicfg_pkg::*;
(
  input  logic [CFG_DW-1:0] index_i,
  input  logic [2:0]        off_i,
  output logic [CFG_DW-1:0] addr_o
);
  localparam int SLOT_LO = 11;

  logic              found;
  logic [4:0]        pos;
  logic [CFG_DW-1:0] slot_f;

  // lowest set bit of index[31:11]; scan downward so the last hit wins
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int b = CFG_DW - 1; b >= SLOT_LO; b--) begin
      if (index_i[b]) begin
        found = 1'b1;
        pos   = 5'(b);
      end
    end
    slot_f = found ? {16'b0, pos, 11'b0} : 32'hFFFF_F800;
  end

  always_comb begin
    if (index_i[31])
      addr_o = index_i | {30'b0, off_i[1:0]};
    else if (index_i[0])
      addr_o = {index_i[31:3], off_i};
    else
      addr_o = {24'b0, index_i[7:3], off_i} | slot_f | {21'b0, index_i[10:8], 8'b0};
  end
endmodule

// File: rtl/pcicfg_lane_map.sv
module pcicfg_lane_map
  import pcicfg_pkg::*;
(
  input  logic [1:0]          size_i,
  input  logic [1:0]          off_i,
  input  logic [CFG_DW-1:0]   wdata_i,
  input  logic [CFG_DW-1:0]   rdata_raw_i,
  output logic [CFG_BE_W-1:0] be_o,
  output logic [CFG_DW-1:0]   wdata_o,
  output logic [CFG_DW-1:0]   rdata_o
);
  logic [1:0]          lane;
  logic [CFG_BE_W-1:0] base_be;
  logic [CFG_DW-1:0]   mask;

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: begin lane = off_i;           base_be = 4'b0001; mask = 32'h0000_00FF; end
      SZ_HALF: begin lane = {off_i[1], 1'b0}; base_be = 4'b0011; mask = 32'h0000_FFFF; end
      default: begin lane = 2'b00;           base_be = 4'b1111; mask = 32'hFFFF_FFFF; end
    endcase
    be_o    = base_be << lane;
    wdata_o = wdata_i << {lane, 3'b000};
    rdata_o = (rdata_raw_i >> {lane, 3'b000}) & mask;
  end
endmodule

// File: rtl/pcicfg_intx_rotate.sv
module pcicfg_intx_rotate
  import pcicfg_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEVFN_W = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_DEV-1:0][DEVFN_W-1:0]  devfn_i,
  input  logic [NUM_DEV-1:0][PIN_N-1:0]    level_i,
  output logic [INTX_N-1:0]                intx_o
);
  localparam int DEVNUM_LO = 11;

  logic [NUM_DEV-1:0][INTX_N-1:0] dev_hits;
  logic [INTX_N-1:0]              merged;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic [INTX_N-1:0] hits;
    always_comb begin
      logic [4:0] sum;
      hits = '0;
      for (int p = 0; p < PIN_N; p++) begin
        sum = devfn_i[g][DEVNUM_LO +: 5] + 5'(p);
        hits[sum[1:0]] = hits[sum[1:0]] | level_i[g][p];
      end
    end
    assign dev_hits[g] = hits;
  end

  always_comb begin
    merged = '0;
    for (int d = 0; d < NUM_DEV; d++) merged = merged | dev_hits[d];
  end

  always_ff @(posedge clk) begin
    if (rst) intx_o <= '0;
    else     intx_o <= merged;
  end
endmodule

// File: rtl/pcicfg_bridge.sv
module pcicfg_bridge
  import pcicfg_pkg::*;
#(
  parameter int WIN_AW  = 12,
  parameter int NUM_DEV = 4,
  parameter int DEVFN_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cpu_req_valid,
  output logic                            cpu_req_ready,
  input  logic                            cpu_req_write,
  input  logic [WIN_AW:0]                 cpu_req_addr,
  input  logic [1:0]                      cpu_req_size,
  input  logic [CFG_DW-1:0]               cpu_req_wdata,
  output logic                            cpu_rsp_valid,
  output logic [CFG_DW-1:0]               cpu_rsp_rdata,
  output logic                            dn_req_valid,
  input  logic                            dn_req_ready,
  output logic                            dn_req_write,
  output logic [CFG_DW-1:0]               dn_req_addr,
  output logic [CFG_BE_W-1:0]             dn_req_be,
  output logic [CFG_DW-1:0]               dn_req_wdata,
  input  logic                            dn_rsp_valid,
  input  logic [CFG_DW-1:0]               dn_rsp_rdata,
  input  logic [NUM_DEV-1:0][DEVFN_W-1:0] irq_devfn,
  input  logic [NUM_DEV-1:0][PIN_N-1:0]   irq_level,
  output logic [INTX_N-1:0]               intx_out
);
  localparam int SEL_BIT = WIN_AW;

  fsm_e                state;
  logic [CFG_DW-1:0]   index_q;
  logic [1:0]          size_q;
  logic [1:0]          off_q;

  logic                sel_data;
  logic [1:0]          lm_size;
  logic [1:0]          lm_off;
  logic [CFG_BE_W-1:0] lane_be;
  logic [CFG_DW-1:0]   lane_wdata;
  logic [CFG_DW-1:0]   lane_rdata;
  logic [CFG_DW-1:0]   xlat_addr;
  logic [CFG_DW-1:0]   index_next;
  logic                unused_addr_bits;

  assign sel_data         = cpu_req_addr[SEL_BIT];
  assign unused_addr_bits = ^cpu_req_addr[WIN_AW-1:3];
  assign cpu_req_ready    = (state == ST_IDLE);

  // lane mapper is shared: request fields while idle, stored fields on return
  assign lm_size = (state == ST_IDLE) ? cpu_req_size     : size_q;
  assign lm_off  = (state == ST_IDLE) ? cpu_req_addr[1:0] : off_q;

  pcicfg_lane_map u_lane (
    .size_i      (lm_size),
    .off_i       (lm_off),
    .wdata_i     (cpu_req_wdata),
    .rdata_raw_i (dn_rsp_rdata),
    .be_o        (lane_be),
    .wdata_o     (lane_wdata),
    .rdata_o     (lane_rdata)
  );

  pcicfg_addr_xlat u_xlat (
    .index_i (index_q),
    .off_i   (cpu_req_addr[2:0]),
    .addr_o  (xlat_addr)
  );

  pcicfg_intx_rotate #(
    .NUM_DEV (NUM_DEV),
    .DEVFN_W (DEVFN_W)
  ) u_intx (
    .clk     (clk),
    .rst     (rst),
    .devfn_i (irq_devfn),
    .level_i (irq_level),
    .intx_o  (intx_out)
  );

  always_comb begin
    for (int b = 0; b < CFG_BE_W; b++)
      index_next[8*b +: 8] = lane_be[b] ? lane_wdata[8*b +: 8] : index_q[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      index_q       <= '0;
      size_q        <= '0;
      off_q         <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
      dn_req_valid  <= 1'b0;
      dn_req_write  <= 1'b0;
      dn_req_addr   <= '0;
      dn_req_be     <= '0;
      dn_req_wdata  <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            if (!sel_data) begin
              if (cpu_req_write) begin
                index_q <= index_next;
              end else begin
                cpu_rsp_valid <= 1'b1;
                cpu_rsp_rdata <= index_q;
              end
            end else begin
              dn_req_valid <= 1'b1;
              dn_req_write <= cpu_req_write;
              dn_req_addr  <= xlat_addr;
              dn_req_be    <= lane_be;
              dn_req_wdata <= lane_wdata;
              size_q       <= cpu_req_size;
              off_q        <= cpu_req_addr[1:0];
              state        <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (dn_req_ready) begin
            dn_req_valid <= 1'b0;
            state        <= dn_req_write ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dn_rsp_valid) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= lane_rdata;
            state         <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcicfg_bridge_chk.sv
module pcicfg_bridge_chk #(
  parameter int NUM_DEV = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cpu_req_ready,
  input logic                       cpu_rsp_valid,
  input logic                       dn_req_valid,
  input logic                       dn_req_ready,
  input logic [31:0]                dn_req_addr,
  input logic [3:0]                 dn_req_be,
  input logic                       dn_rsp_valid,
  input logic [NUM_DEV-1:0][3:0]    irq_level,
  input logic [3:0]                 intx_out
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_be));

  assert_cpu_stall_R9: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> !cpu_req_ready);

  assert_rsp_follow_R9: assert property (@(posedge clk) disable iff (rst)
    dn_rsp_valid && !cpu_req_ready && !dn_req_valid |=> cpu_rsp_valid);

  assert_be_legal_R7: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> (dn_req_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF}));

  assert_intx_source_R10: assert property (@(posedge clk) disable iff (rst)
    (|intx_out) |-> $past(|irq_level));

  assert_reset_clean_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dn_req_valid && !cpu_rsp_valid && intx_out == 4'h0);
endmodule

bind pcicfg_bridge pcicfg_bridge_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .dn_req_valid  (dn_req_valid),
  .dn_req_ready  (dn_req_ready),
  .dn_req_addr   (dn_req_addr),
  .dn_req_be     (dn_req_be),
  .dn_rsp_valid  (dn_rsp_valid),
  .irq_level     (irq_level),
  .intx_out      (intx_out)
);

// File: tb/pcicfg_bridge_bench.sv
module pcicfg_bridge_bench;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_req_valid = 1'b0;
  logic              cpu_req_ready;
  logic              cpu_req_write = 1'b0;
  logic [12:0]       cpu_req_addr = '0;
  logic [1:0]        cpu_req_size = '0;
  logic [31:0]       cpu_req_wdata = '0;
  logic              cpu_rsp_valid;
  logic [31:0]       cpu_rsp_rdata;
  logic              dn_req_valid;
  logic              dn_req_ready = 1'b0;
  logic              dn_req_write;
  logic [31:0]       dn_req_addr;
  logic [3:0]        dn_req_be;
  logic [31:0]       dn_req_wdata;
  logic              dn_rsp_valid = 1'b0;
  logic [31:0]       dn_rsp_rdata = '0;
  logic [3:0][15:0]  irq_devfn = '0;
  logic [3:0][3:0]   irq_level = '0;
  logic [3:0]        intx_out;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  int          stall_cfg = 0;
  int          rsp_delay_cfg = 0;
  logic [31:0] rsp_data = '0;
  int          stall_cnt = 0;
  int          rsp_cnt = 0;
  bit          rsp_pend = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_be;
  logic        cap_write;

  always #2.5 clk = ~clk;

  pcicfg_bridge u_pcicfg_bridge (
    .clk, .rst, .cpu_req_valid, .cpu_req_ready, .cpu_req_write, .cpu_req_addr,
    .cpu_req_size, .cpu_req_wdata, .cpu_rsp_valid, .cpu_rsp_rdata,
    .dn_req_valid, .dn_req_ready, .dn_req_write, .dn_req_addr, .dn_req_be,
    .dn_req_wdata, .dn_rsp_valid, .dn_rsp_rdata, .irq_devfn, .irq_level, .intx_out
  );

  // downstream responder, acts on falling edges
  always @(negedge clk) begin
    if (rst) begin
      dn_req_ready = 0; dn_rsp_valid = 0; rsp_pend = 0; stall_cnt = 0;
    end else begin
      dn_rsp_valid = 0;
      if (dn_req_ready) begin
        dn_req_ready = 0;
        if (!cap_write) begin rsp_pend = 1; rsp_cnt = rsp_delay_cfg; end
      end else if (dn_req_valid) begin
        if (stall_cnt >= stall_cfg) begin
          dn_req_ready = 1; stall_cnt = 0;
          cap_addr = dn_req_addr; cap_be = dn_req_be;
          cap_wdata = dn_req_wdata; cap_write = dn_req_write;
        end else stall_cnt++;
      end
      if (rsp_pend) begin
        if (rsp_cnt == 0) begin dn_rsp_valid = 1; dn_rsp_rdata = rsp_data; rsp_pend = 0; end
        else rsp_cnt--;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [12:0] addr, input logic [1:0] sz,
                       input logic [31:0] wd);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = addr;
    cpu_req_size = sz; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 0;
  endtask

  task automatic cpu_write(input logic [12:0] addr, input logic [1:0] sz, input logic [31:0] wd,
                           output bit saw_rsp);
    int n = 0;
    saw_rsp = 0;
    issue(1'b1, addr, sz, wd);
    while (!cpu_req_ready && n < 100) begin
      if (cpu_rsp_valid) saw_rsp = 1;
      @(negedge clk); n++;
    end
    if (cpu_rsp_valid) saw_rsp = 1;
  endtask

  task automatic cpu_read(input logic [12:0] addr, input logic [1:0] sz, output logic [31:0] rd,
                          output logic ready_after);
    int n = 0;
    issue(1'b0, addr, sz, 32'h0);
    ready_after = cpu_req_ready;
    while (!cpu_rsp_valid && n < 100) begin @(negedge clk); n++; end
    rd = cpu_rsp_valid ? cpu_rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic t_reset;
    check("R11 intx after reset", {28'b0, intx_out}, 32'h0);
    check("R11 dn_req_valid after reset", {31'b0, dn_req_valid}, 32'h0);
    check("R11 cpu_rsp_valid after reset", {31'b0, cpu_rsp_valid}, 32'h0);
    check("R11 cpu_req_ready after reset", {31'b0, cpu_req_ready}, 32'h1);
  endtask

  task automatic t_index;
    logic [31:0] rd; logic rdy; bit s;
    cpu_read(13'h0000, 2'd2, rd, rdy);
    check("R1 index reset value", rd, 32'h0);
    cpu_write(13'h0000, 2'd2, 32'h1234_5678, s);
    cpu_read(13'h0000, 2'd2, rd, rdy);
    check("R1 index word readback", rd, 32'h1234_5678);
    cpu_write(13'h0001, 2'd0, 32'h0000_00AB, s);
    cpu_read(13'h0000, 2'd2, rd, rdy);
    check("R7 index byte write lane 1", rd, 32'h1234_AB78);
    cpu_write(13'h0002, 2'd1, 32'h0000_CDEF, s);
    cpu_read(13'h07FE, 2'd0, rd, rdy);
    check("R1 index read ignores offset/size", rd, 32'hCDEF_AB78);
    check("R2 index accesses make no downstream request", {31'b0, dn_req_valid}, 32'h0);
  endtask

  task automatic t_type1_write;
    bit s; logic [31:0] rd; logic rdy;
    cpu_write(13'h0000, 2'd2, 32'h0001_2345, s);
    cpu_write(13'h1006, 2'd0, 32'h0000_005A, s);
    check("R4 type-1 address", cap_addr, 32'h0001_2346);
    check("R7 byte enables byte at off 2", {28'b0, cap_be}, 32'h4);
    check("R7 write data lane shift", cap_wdata, 32'h005A_0000);
    check("R8 write request flag", {31'b0, cap_write}, 32'h1);
    check("R8 posted write gives no response", {31'b0, s}, 32'h0);
    cpu_read(13'h0000, 2'd2, rd, rdy);
    check("R2 data write leaves index intact", rd, 32'h0001_2345);
  endtask

  task automatic t_pass_read;
    bit s; logic [31:0] rd; logic rdy;
    stall_cfg = 2; rsp_delay_cfg = 3; rsp_data = 32'hAABB_CCDD;
    cpu_write(13'h0000, 2'd2, 32'h8000_1234, s);
    cpu_read(13'h1003, 2'd0, rd, rdy);
    check("R9 cpu stalled during read", {31'b0, rdy}, 32'h0);
    check("R3 pass-through address", cap_addr, 32'h8000_1237);
    check("R7 byte enables byte at off 3", {28'b0, cap_be}, 32'h8);
    check("R9 read data byte lane 3", rd, 32'h0000_00AA);
    stall_cfg = 0; rsp_delay_cfg = 0;
  endtask

  task automatic t_type0;
    bit s; logic [31:0] rd; logic rdy;
    rsp_data = 32'h1122_3344;
    cpu_write(13'h0000, 2'd2, 32'h0000_0A10, s);
    cpu_read(13'h1001, 2'd0, rd, rdy);
    check("R5 type-0 slot 11 function 2", cap_addr, 32'h0000_5A11);
    check("R9 read data byte lane 1", rd, 32'h0000_0033);
    cpu_write(13'h0000, 2'd2, 32'h0010_1520, s);
    cpu_read(13'h1002, 2'd1, rd, rdy);
    check("R5 lowest set bit wins", cap_addr, 32'h0000_6522);
    check("R7 half enables upper", {28'b0, cap_be}, 32'hC);
    check("R9 read data half upper", rd, 32'h0000_1122);
    cpu_write(13'h0000, 2'd2, 32'h4000_0000, s);
    cpu_read(13'h1000, 2'd2, rd, rdy);
    check("R5 slot 30", cap_addr, 32'h0000_F000);
    check("R7 word enables", {28'b0, cap_be}, 32'hF);
    check("R9 word read data", rd, 32'h1122_3344);
  endtask

  task automatic t_noslot;
    bit s;
    cpu_write(13'h0000, 2'd2, 32'h0000_0306, s);
    cpu_write(13'h1004, 2'd3, 32'hCAFE_F00D, s);
    check("R6 empty select fills bits 31:11", cap_addr, 32'hFFFF_FB04);
    check("R7 size code 3 as word", {28'b0, cap_be}, 32'hF);
    check("R7 word write data unshifted", cap_wdata, 32'hCAFE_F00D);
  endtask

  task automatic t_intx;
    irq_devfn[0] = 16'h0000; irq_devfn[1] = 16'h0800;
    irq_devfn[2] = 16'h7800; irq_devfn[3] = 16'h5800;
    irq_level = '0; irq_level[1][1] = 1'b1;
    @(negedge clk);
    check("R10 dev1 pinB to out2", {28'b0, intx_out}, 32'h4);
    irq_level = '0; irq_level[2][2] = 1'b1;
    @(negedge clk);
    check("R10 dev15 pinC wraps to out1", {28'b0, intx_out}, 32'h2);
    irq_level = '0; irq_level[2][1] = 1'b1;
    @(negedge clk);
    check("R10 dev15 pinB wraps to out0", {28'b0, intx_out}, 32'h1);
    irq_level = '0; irq_level[3][0] = 1'b1; irq_level[0][0] = 1'b1;
    @(negedge clk);
    check("R10 two sources two outputs", {28'b0, intx_out}, 32'h9);
    irq_level = '0; irq_level[0][0] = 1'b1; irq_level[1][3] = 1'b1;
    @(negedge clk);
    check("R10 shared output ORed", {28'b0, intx_out}, 32'h1);
    irq_level[0][0] = 1'b0;
    @(negedge clk);
    check("R10 output follows remaining level", {28'b0, intx_out}, 32'h1);
    irq_level = '0;
    @(negedge clk);
    check("R10 all released", {28'b0, intx_out}, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_index;
    t_type1_write;
    t_pass_read;
    t_type0;
    t_noslot;
    t_intx;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule